// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the lower memory. Processor stores go into a small queue of block-sized entries, so the store retires at once and does not wait for memory. A store whose block already has an open entry is folded into that entry. A per-byte valid mask records which bytes the stores have written. Entries leave in the order they were allocated. Each one goes out as a single block-wide write that carries byte enables.

Every processor read is checked against the queued stores. If the newest entry for the read's block holds every requested byte, the read is answered from the buffer. If an entry for that block exists but lacks some requested bytes, the read is held back until those entries have drained. A read that misses the buffer is given the memory port ahead of pending writes.

One memory port is shared by reads and writes and is run by a three-state machine:
- `PS_IDLE` goes to `PS_READ` when a read misses the buffer. Otherwise it goes to `PS_WRITE` when any entry is queued.
- `PS_READ` returns to `PS_IDLE` on grant.
- `PS_WRITE` returns to `PS_IDLE` on grant, and the oldest entry leaves in that cycle.

While the machine is in `PS_WRITE`, the oldest entry is closed to further merging.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset the buffer is empty. `mem_req` is low, `st_stall` is low, and no read is forwarded or flagged as conflicting. Entries present before reset are discarded.
- R2: A store is decoded as follows. Its block is `st_waddr[29:2]`, its word in the block is `st_waddr[1:0]`, and `st_be` bit b enables byte b (bits 8b+7..8b) of `st_data`. A store to a block with no open entry takes a free entry without stalling. The unwritten bytes of that entry read as zero and are marked not valid.
- R3: A store to a block that has an open entry is merged into it and uses no new entry. Newly written bytes replace older ones, and the valid mask becomes the union of the two masks.
- R4: `st_stall` is high exactly when a store is offered, every entry is in use and the store cannot merge. A stalled store changes nothing. A merging store is accepted even when the buffer is full.
- R5: Each entry drains as one write request with `mem_we`=1. `mem_addr` is the block's byte address with bits 3:0 zero. Block byte j travels on `mem_wdata` bits 8j+7..8j, and `mem_wbe` bit j is that byte's valid flag.
- R6: Entries drain in allocation order. An entry leaves the buffer in the cycle where `mem_gnt` is high with its request.
- R7: A raised request, with its address, data and byte enables, stays unchanged until granted. Once the oldest entry's drain request is raised, that entry takes no further merges. A later store to the same block opens a new entry.
- R8: A read is a full hit when the newest entry for its block holds all requested bytes. On a full hit, `rd_fwd` and `rd_ack` are high in the same cycle, `rd_data` carries that entry's word, and no memory read is made. A store is visible to this check from the cycle after it is accepted.
- R9: A read is a partial hit when some entry matches its block but the newest one lacks a requested byte. On a partial hit, `rd_conflict` is high and no memory read is issued while any matching entry remains. Write draining goes on meanwhile.
- R10: In `PS_IDLE`, a read that misses the buffer wins the port over pending writes. The read request has `mem_we`=0 and `mem_addr` equal to the read's block byte address. `rd_ack` is high in the cycle it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered this cycle |
| st_waddr | input | 30 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_stall | output | 1 | Store not accepted this cycle |
| rd_valid | input | 1 | Read to be checked, held until `rd_ack` |
| rd_waddr | input | 30 | Read word address |
| rd_be | input | 4 | Bytes the read needs |
| rd_fwd | output | 1 | Read answered from the buffer |
| rd_conflict | output | 1 | Read blocked by a partly covering entry |
| rd_data | output | 32 | Forwarded word |
| rd_ack | output | 1 | Read resolved this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a block write |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wdata | output | 128 | Block write data |
| mem_wbe | output | 16 | Block write byte enables |
| mem_gnt | input | 1 | Memory takes the request this cycle |

## Verification
The assertions assume the processor behaves as a blocking load unit. It holds `rd_valid` and `rd_waddr` steady until `rd_ack`, offers no store while its own read request waits for memory, and never raises `rd_valid` with `rd_be` all zero. The bench follows these rules. Each read is held until acknowledged or withdrawn, stores and reads are driven only on the falling edge, and the stores used to set up a conflict are issued before the read that depends on them.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_READ  = 2'd1,
        PS_WRITE = 2'd2
    } port_state_e;
endpackage

// File: rtl/wbuf_lookup.sv
`timescale 1ns/1ps
// Finds the youngest occupied entry whose block tag equals the query.
module wbuf_lookup #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 28,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input  logic [PTR_W-1:0]         head,
    input  logic [ENTRIES-1:0]       occ,
    input  logic [ENTRIES*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]         query,
    output logic                     found,
    output logic [PTR_W-1:0]         newest
);
    logic [ENTRIES-1:0] match;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = occ[g] && (tags[g*TAG_W +: TAG_W] == query);
        end
    endgenerate

    // walk from oldest to youngest; the last match wins
    always_comb begin
        logic [PTR_W-1:0] idx;
        found  = |match;
        newest = head;
        for (int k = 0; k < ENTRIES; k++) begin
            idx = head + PTR_W'(k);
            if (match[idx]) newest = idx;
        end
    end
endmodule

// File: rtl/wbuf_port_fsm.sv
`timescale 1ns/1ps
// Arbitrates the single memory port between read misses and block drains.
module wbuf_port_fsm
    import wbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_miss,
    input  logic pending,
    input  logic mem_gnt,
    output logic mem_req,
    output logic mem_we,
    output logic drain_lock,
    output logic drain_done,
    output logic rd_mem_done
);
    port_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (rd_miss)      state_d = PS_READ;
                else if (pending) state_d = PS_WRITE;
            end
            PS_READ:  if (mem_gnt) state_d = PS_IDLE;
            PS_WRITE: if (mem_gnt) state_d = PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        drain_lock  = 1'b0;
        drain_done  = 1'b0;
        rd_mem_done = 1'b0;
        unique case (state_q)
            PS_IDLE: ;
            PS_READ: begin
                mem_req     = 1'b1;
                rd_mem_done = mem_gnt;
            end
            PS_WRITE: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                drain_lock = 1'b1;
                drain_done = mem_gnt;
            end
            default: ;
        endcase
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && (mem_we == $past(mem_we))));
endmodule

// File: rtl/store_merge_buffer.sv
`timescale 1ns/1ps
module store_merge_buffer #(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 4,
    parameter int ENTRIES = 4,
    localparam int BYTES_W    = WORD_W / 8,
    localparam int BSEL_W     = $clog2(BYTES_W),
    localparam int WSEL_W     = $clog2(WORDS),
    localparam int OFF_W      = BSEL_W + WSEL_W,
    localparam int WA_W       = ADDR_W - BSEL_W,
    localparam int LINE_W     = WORDS * WORD_W,
    localparam int LINE_BYTES = WORDS * BYTES_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    input  logic [WA_W-1:0]       st_waddr,
    input  logic [WORD_W-1:0]     st_data,
    input  logic [BYTES_W-1:0]    st_be,
    output logic                  st_stall,
    input  logic                  rd_valid,
    input  logic [WA_W-1:0]       rd_waddr,
    input  logic [BYTES_W-1:0]    rd_be,
    output logic                  rd_fwd,
    output logic                  rd_conflict,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  rd_ack,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_W-1:0]     mem_wdata,
    output logic [LINE_BYTES-1:0] mem_wbe,
    input  logic                  mem_gnt
);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int PTR_W = $clog2(ENTRIES);
    localparam int CNT_W = $clog2(ENTRIES + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);

    // entry storage, kept as a circular queue
    logic [TAG_W-1:0]      tag_q  [ENTRIES];
    logic [LINE_W-1:0]     line_q [ENTRIES];
    logic [LINE_BYTES-1:0] mask_q [ENTRIES];
    logic [PTR_W-1:0]      head_q, tail_q;
    logic [CNT_W-1:0]      count_q;

    logic [ENTRIES-1:0]       occ;
    logic [ENTRIES*TAG_W-1:0] tags_flat;
    logic [PTR_W-1:0]         age [ENTRIES];

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_ent
            assign age[g] = PTR_W'(g) - head_q;
            assign occ[g] = CNT_W'(age[g]) < count_q;
            assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
        end
    endgenerate

    // port control
    logic drain_lock, drain_done, rd_mem_done, rd_miss;

    // store side
    logic [TAG_W-1:0]      st_tag;
    logic [WSEL_W-1:0]     st_wsel;
    logic                  st_found, st_merge, st_take, st_alloc;
    logic [PTR_W-1:0]      st_newest, st_idx;
    logic [LINE_BYTES-1:0] st_lanes;
    logic [LINE_W-1:0]     st_line;

    assign st_tag  = st_waddr[WA_W-1:WSEL_W];
    assign st_wsel = st_waddr[WSEL_W-1:0];

    wbuf_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_st_look (
        .head(head_q), .occ(occ), .tags(tags_flat), .query(st_tag),
        .found(st_found), .newest(st_newest)
    );

    always_comb begin
        st_merge = st_found && !(drain_lock && (st_newest == head_q));
        st_stall = st_valid && !st_merge && (count_q == FULL_CNT);
        st_take  = st_valid && !st_stall;
        st_alloc = st_take && !st_merge;
        st_idx   = st_merge ? st_newest : tail_q;
        st_lanes = LINE_BYTES'(st_be) << (st_wsel * BYTES_W);
        st_line  = {WORDS{st_data}};
    end

    // read side
    logic [TAG_W-1:0]      rd_tag;
    logic [WSEL_W-1:0]     rd_wsel;
    logic                  rd_found, rd_cover;
    logic [PTR_W-1:0]      rd_newest;
    logic [LINE_BYTES-1:0] rd_need;

    assign rd_tag  = rd_waddr[WA_W-1:WSEL_W];
    assign rd_wsel = rd_waddr[WSEL_W-1:0];

    wbuf_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_rd_look (
        .head(head_q), .occ(occ), .tags(tags_flat), .query(rd_tag),
        .found(rd_found), .newest(rd_newest)
    );

    always_comb begin
        rd_need     = LINE_BYTES'(rd_be) << (rd_wsel * BYTES_W);
        rd_cover    = (mask_q[rd_newest] & rd_need) == rd_need;
        rd_fwd      = rd_valid && rd_found && rd_cover;
        rd_conflict = rd_valid && rd_found && !rd_cover;
        rd_miss     = rd_valid && !rd_found;
        rd_data     = line_q[rd_newest][rd_wsel*WORD_W +: WORD_W];
        rd_ack      = rd_fwd || rd_mem_done;
    end

    wbuf_port_fsm u_port (
        .clk(clk), .rst_n(rst_n), .rd_miss(rd_miss), .pending(count_q != '0),
        .mem_gnt(mem_gnt), .mem_req(mem_req), .mem_we(mem_we),
        .drain_lock(drain_lock), .drain_done(drain_done), .rd_mem_done(rd_mem_done)
    );

    always_comb begin
        mem_addr  = mem_we ? {tag_q[head_q], OFF_W'(0)} : {rd_tag, OFF_W'(0)};
        mem_wdata = line_q[head_q];
        mem_wbe   = mask_q[head_q];
    end

    // queue update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                tag_q[e]  <= '0;
                line_q[e] <= '0;
                mask_q[e] <= '0;
            end
        end else begin
            if (st_take) begin
                for (int j = 0; j < LINE_BYTES; j++) begin
                    if (st_lanes[j])   line_q[st_idx][8*j +: 8] <= st_line[8*j +: 8];
                    else if (st_alloc) line_q[st_idx][8*j +: 8] <= 8'h00;
                end
                mask_q[st_idx] <= st_alloc ? st_lanes : (mask_q[st_idx] | st_lanes);
            end
            if (st_alloc) begin
                tag_q[tail_q] <= st_tag;
                tail_q        <= tail_q + PTR_W'(1);
            end
            if (drain_done) head_q <= head_q + PTR_W'(1);
            unique case ({st_alloc, drain_done})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);
    // R7
    line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_gnt) |=>
        ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_wbe)));
    // R5
    wbe_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wbe != '0));
    // R8
    fwd_no_memread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fwd |-> !(mem_req && !mem_we));
    // R9
    conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_conflict |-> !(mem_req && !mem_we));
endmodule

// File: tb/sim_store_merge_buffer.sv
`timescale 1ns/1ps
module sim_store_merge_buffer;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0, rd_valid = 1'b0, mem_gnt = 1'b0;
    logic [31:0]  st_addr = '0, rd_addr = '0, st_data = '0;
    logic [3:0]   st_be = '0, rd_be = '0;
    logic         st_stall, rd_fwd, rd_conflict, rd_ack, mem_req, mem_we;
    logic [31:0]  rd_data, mem_addr;
    logic [127:0] mem_wdata;
    logic [15:0]  mem_wbe;

    store_merge_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_waddr(st_addr[31:2]), .st_data(st_data), .st_be(st_be),
        .st_stall(st_stall),
        .rd_valid(rd_valid), .rd_waddr(rd_addr[31:2]), .rd_be(rd_be),
        .rd_fwd(rd_fwd), .rd_conflict(rd_conflict), .rd_data(rd_data), .rd_ack(rd_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wbe(mem_wbe), .mem_gnt(mem_gnt)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // captured block writes
    logic [31:0]  cap_addr [8];
    logic [127:0] cap_data [8];
    logic [15:0]  cap_be   [8];
    int ncap = 0;
    always @(negedge clk) begin
        #1;
        if (mem_req && mem_we && mem_gnt && ncap < 8) begin
            cap_addr[ncap] = mem_addr;
            cap_data[ncap] = mem_wdata;
            cap_be[ncap]   = mem_wbe;
            ncap++;
        end
    end

    // {rd, addr[31:0], data[31:0], be[3:0], kind[1:0]}
    // store kind: 0 accepted, 1 stalled; read kind: 0 forwarded, 1 conflict, 2 miss
    localparam int NV = 16;
    localparam logic [70:0] TBL [NV] = '{
        {1'b0, 32'h100, 32'h11111111, 4'hF, 2'd0},
        {1'b0, 32'h204, 32'hAABBCCDD, 4'hF, 2'd0},
        {1'b0, 32'h204, 32'h000000EE, 4'h1, 2'd0},
        {1'b0, 32'h208, 32'h12345678, 4'hC, 2'd0},
        {1'b1, 32'h204, 32'hAABBCCEE, 4'hF, 2'd0},
        {1'b1, 32'h208, 32'h12340000, 4'hC, 2'd0},
        {1'b1, 32'h208, 32'h00000000, 4'hF, 2'd1},
        {1'b1, 32'h300, 32'h00000000, 4'hF, 2'd2},
        {1'b0, 32'h100, 32'h22222222, 4'h3, 2'd0},
        {1'b1, 32'h100, 32'h00002222, 4'h3, 2'd0},
        {1'b1, 32'h100, 32'h00000000, 4'hF, 2'd1},
        {1'b0, 32'h30C, 32'hCAFEF00D, 4'hF, 2'd0},
        {1'b0, 32'h400, 32'h00000001, 4'hF, 2'd1},
        {1'b0, 32'h300, 32'h0BADBEEF, 4'hF, 2'd0},
        {1'b1, 32'h30C, 32'hCAFEF00D, 4'hF, 2'd0},
        {1'b1, 32'h400, 32'h00000000, 4'hF, 2'd2}
    };

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check("R1 stall", st_stall, 0);
        check("R1 req", mem_req, 0);
        check("R1 ack", rd_ack, 0);

        // vector table, memory grant held low
        for (int i = 0; i < NV; i++) begin
            logic [70:0] v;
            v = TBL[i];
            @(negedge clk);
            if (v[70]) begin
                st_valid = 0; rd_valid = 1; rd_addr = v[69:38]; rd_be = v[5:2];
            end else begin
                rd_valid = 0; st_valid = 1; st_addr = v[69:38]; st_data = v[37:6]; st_be = v[5:2];
            end
            #1;
            if (!v[70]) begin
                if (v[1:0] == 2'd1) check("R4 stall when full", st_stall, 1);
                else                check("R2 R3 store accepted", st_stall, 0);
            end else if (v[1:0] == 2'd0) begin
                check("R8 forward", {rd_fwd, rd_conflict, rd_ack}, 3'b101);
                check("R3 R8 data", rd_data, v[37:6]);
            end else if (v[1:0] == 2'd1) begin
                check("R9 conflict", {rd_fwd, rd_conflict}, 2'b01);
            end else begin
                check("R8 miss", {rd_fwd, rd_conflict}, 2'b00);
            end
        end
        @(negedge clk); st_valid = 0; rd_valid = 0;
        repeat (3) @(negedge clk);
        #1;
        // R7 oldest request held, untouched by the later store to its block
        check("R7 held req", {mem_req, mem_we, mem_addr}, {2'b11, 32'h100});
        check("R7 closed entry", mem_wbe, 16'h000F);

        // drain all
        @(negedge clk); mem_gnt = 1;
        repeat (20) @(negedge clk);
        #1;
        check("R6 drain count", ncap, 4);
        check("R6 order 0", cap_addr[0], 32'h100);
        check("R6 order 1", cap_addr[1], 32'h200);
        check("R6 order 2", cap_addr[2], 32'h100);
        check("R6 order 3", cap_addr[3], 32'h300);
        check("R5 data 0", cap_data[0], 128'h11111111);
        check("R5 be 0", cap_be[0], 16'h000F);
        check("R5 data 1", cap_data[1], {32'h0, 32'h12340000, 32'hAABBCCEE, 32'h0});
        check("R5 be 1", cap_be[1], 16'h0CF0);
        check("R5 data 2", cap_data[2], 128'h00002222);
        check("R5 be 2", cap_be[2], 16'h0003);
        check("R5 data 3", cap_data[3], {32'hCAFEF00D, 64'h0, 32'h0BADBEEF});
        check("R5 be 3", cap_be[3], 16'hF00F);
        check("R6 empty", mem_req, 0);
        mem_gnt = 0;

        // R10 read miss beats a pending write
        @(negedge clk); st_valid = 1; st_addr = 32'h500; st_data = 32'h55; st_be = 4'hF;
        @(negedge clk); st_valid = 0; rd_valid = 1; rd_addr = 32'h904; rd_be = 4'hF;
        @(negedge clk); #1;
        check("R10 read first", {mem_req, mem_we, mem_addr, rd_ack}, {2'b10, 32'h900, 1'b0});
        mem_gnt = 1; #1;
        check("R10 ack on grant", rd_ack, 1);
        @(negedge clk); rd_valid = 0;
        repeat (6) @(negedge clk);
        #1;
        check("R10 write after read", ncap, 5);
        check("R10 write addr", cap_addr[4], 32'h500);
        mem_gnt = 0;

        // R9 partial hit waits for drain
        @(negedge clk); st_valid = 1; st_addr = 32'h600; st_data = 32'h66; st_be = 4'h1;
        @(negedge clk); st_valid = 0;
        @(negedge clk); rd_valid = 1; rd_addr = 32'h600; rd_be = 4'hF; #1;
        check("R9 conflict flag", rd_conflict, 1);
        check("R9 port writes", {mem_req, mem_we}, 2'b11);
        mem_gnt = 1;
        @(negedge clk); #1;
        check("R9 cleared", {rd_conflict, rd_fwd, mem_req}, 3'b000);
        @(negedge clk); #1;
        check("R9 read issued", {mem_req, mem_we, mem_addr, rd_ack}, {2'b10, 32'h600, 1'b1});
        check("R9 write went first", {ncap, cap_be[5]}, {32'd6, 16'h0001});
        rd_valid = 0; mem_gnt = 0;

        // R1 reset discards a buffered store
        @(negedge clk); st_valid = 1; st_addr = 32'h700; st_data = 32'h77; st_be = 4'hF;
        @(negedge clk); st_valid = 0; rst_n = 0;
        @(negedge clk); rst_n = 1; rd_valid = 1; rd_addr = 32'h700; rd_be = 4'hF; #1;
        check("R1 discarded", {rd_fwd, rd_conflict}, 2'b00);
        @(negedge clk); rd_valid = 0;
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            finish_run();
        end
    end
endmodule